// File: doc/BRIEF.md
# Full-Speed USB Oversampling Line Receiver

This block takes the two raw USB data lines straight from general-purpose input pins, with no transceiver in front of it, and turns the 12 Mbit/s full-speed stream into bytes. It runs from a 48 MHz clock, so each bit cell spans four samples. Each line is passed through its own synchroniser and treated as a plain single-ended input. The pair is then classified as idle (J, positive line high), K, single-ended zero or the illegal both-high state.

A phase tracker re-centres the sampling point on every transition into J or K. This lets the receiver follow a host whose clock is slightly off, as long as the error stays within ±0.25%. Sampled bits go through sync-pattern hunting, NRZI decoding and stuffed-bit removal, and are assembled least significant bit first. The block reports completed bytes with a one-cycle strobe, together with one-cycle start-of-packet, end-of-packet and error pulses. These pulses feed the packet logic above it, which handles CRC and parsing.

Top module: `usb_fs_rx`

## Requirements
- R1: While reset is held, and afterwards with the line idle in J, rx_valid_o, rx_sop_o, rx_eop_o and rx_err_o stay low and rx_data_o reads zero.
- R2: rx_sop_o pulses for exactly one cycle when the sampled line states K,J,K,J,K,J,K,K (oldest first) arrive with no SE0 or SE1 among them. A run that keeps alternating, such as K,J,K,J,K,J,K,J followed by J, produces no pulse and no bytes.
- R3: After the start of a packet, a sampled level equal to the previous one decodes as 1, and a change decodes as 0. The level in force when the sync pattern ends is K. Every eight data bits produce one rx_valid_o pulse, with the first received bit in rx_data_o[0].
- R4: The decoded 1 that ends the sync pattern counts toward the run of ones. A 0 that arrives after six consecutive decoded 1s is dropped and does not enter any byte, and the run count restarts at zero.
- R5: A 1 that arrives after six consecutive decoded 1s pulses rx_err_o and abandons the packet. No further bytes are reported, and no end-of-packet is reported until a new sync pattern appears.
- R6: Inside a packet, SE0 sampled for at least two bit times and then followed by J pulses rx_eop_o. rx_err_o stays low if the byte count was aligned.
- R7: If a partly assembled byte is pending when a valid end-of-packet is seen, rx_eop_o and rx_err_o pulse together in the same cycle.
- R8: Inside a packet, SE0 that lasts only one bit time before J or K returns, or any sampled SE1, pulses rx_err_o without rx_eop_o and ends the packet.
- R9: At most one sample is taken per bit cell. Packets are still decoded correctly when individual bit cells last three or five clocks instead of four, because the sample point is moved two clocks after each transition into J or K.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | 48 MHz sampling clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| dp_i | input | 1 | Raw positive data line |
| dm_i | input | 1 | Raw negative data line |
| rx_data_o | output | 8 | Most recently completed byte |
| rx_valid_o | output | 1 | One-cycle strobe: rx_data_o holds a new byte |
| rx_sop_o | output | 1 | One-cycle pulse when the sync pattern is found |
| rx_eop_o | output | 1 | One-cycle pulse on a valid end-of-packet |
| rx_err_o | output | 1 | One-cycle pulse on a stuffing, framing or alignment fault |

## Verification
The bench builds its own NRZI and stuffed line waveforms. It targets the 0xFF and 0x7E bytes that force stuffed zeros: a decoder that does not count the last sync bit, or that keeps the stuffed zero, returns shifted or corrupted bytes. It also sends a run of seven ones, which must raise an error and suppress the later end-of-packet; a decoder without this check would accept the run as data. Further cases are a truncated byte at end-of-packet, a one-bit SE0, a near-miss sync pattern that a loose matcher would accept, and bit cells stretched to three and five clocks. That last case is where a tracker that does not re-centre would sample one bit twice or skip one.

// File: rtl/usbfs_rx_pkg.sv
package usbfs_rx_pkg;

    // Pair of line levels packed as {positive, negative}
    typedef enum logic [1:0] {
        LS_SE0 = 2'b00,
        LS_K   = 2'b01,
        LS_J   = 2'b10,
        LS_SE1 = 2'b11
    } line_t;

    typedef enum logic {
        DS_HUNT = 1'b0,
        DS_PKT  = 1'b1
    } dec_st_t;

endpackage

// File: rtl/usbfs_rx_sync.sv
module usbfs_rx_sync
    import usbfs_rx_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic  clk_i,
    input  logic  rst_ni,
    input  logic  dp_i,
    input  logic  dm_i,
    output line_t ls_o
);

    logic [1:0] pins;
    logic [1:0] lvl;

    assign pins = {dp_i, dm_i};

    for (genvar g = 0; g < 2; g++) begin : g_lane
        logic [STAGES-1:0] sh_d, sh_q;

        always_comb begin
            sh_d = {sh_q[STAGES-2:0], pins[g]};
        end

        always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) sh_q <= '0;
            else         sh_q <= sh_d;
        end

        assign lvl[g] = sh_q[STAGES-1];
    end

    assign ls_o = line_t'(lvl);

endmodule

// File: rtl/usbfs_rx_dpll.sv
module usbfs_rx_dpll
    import usbfs_rx_pkg::*;
#(
    parameter int OVS    = 4,
    parameter int CENTER = 2
) (
    input  logic  clk_i,
    input  logic  rst_ni,
    input  line_t ls_i,
    output logic  stb_o,
    output line_t smp_o
);

    localparam int CNT_W = (OVS > 1) ? $clog2(OVS) : 1;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        line_t            prev;
        logic             stb;
        line_t            smp;
    } dpll_t;

    dpll_t cur_q, nxt_d;
    logic  edge_seen;

    always_comb begin
        nxt_d     = cur_q;
        nxt_d.stb = 1'b0;
        edge_seen = (ls_i != cur_q.prev) && ((ls_i == LS_J) || (ls_i == LS_K));
        nxt_d.prev = ls_i;

        if (cur_q.cnt == CNT_W'(CENTER)) begin
            nxt_d.stb = 1'b1;
            nxt_d.smp = ls_i;
        end

        // Edge cycle counts as phase 0; sample lands CENTER clocks later
        if (edge_seen)                           nxt_d.cnt = CNT_W'(1);
        else if (cur_q.cnt == CNT_W'(OVS - 1))   nxt_d.cnt = '0;
        else                                     nxt_d.cnt = cur_q.cnt + 1'b1;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cur_q.cnt  <= '0;
            cur_q.prev <= LS_SE0;
            cur_q.stb  <= 1'b0;
            cur_q.smp  <= LS_SE0;
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign stb_o = cur_q.stb;
    assign smp_o = cur_q.smp;

endmodule

// File: rtl/usbfs_rx_dec.sv
module usbfs_rx_dec
    import usbfs_rx_pkg::*;
#(
    parameter int                DATA_W    = 8,
    parameter int                STUFF_RUN = 6,
    parameter int                EOP_MIN   = 2,
    parameter int                SYNC_LEN  = 8,
    parameter logic [SYNC_LEN-1:0] SYNC_PAT = 8'b1010_1011
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              stb_i,
    input  line_t             smp_i,
    output logic [DATA_W-1:0] data_o,
    output logic              valid_o,
    output logic              sop_o,
    output logic              eop_o,
    output logic              err_o
);

    localparam int ONES_W = $clog2(STUFF_RUN + 2);
    localparam int NB_W   = (DATA_W > 1) ? $clog2(DATA_W) : 1;
    localparam int SE0_W  = $clog2(EOP_MIN + 1);

    typedef struct packed {
        dec_st_t             st;
        logic [SYNC_LEN-1:0] hist;
        logic [SYNC_LEN-1:0] jk;
        logic                lvl;
        logic [ONES_W-1:0]   ones;
        logic [DATA_W-1:0]   sr;
        logic [NB_W-1:0]     nb;
        logic [SE0_W-1:0]    se0;
        logic [DATA_W-1:0]   data;
        logic                valid;
        logic                sop;
        logic                eop;
        logic                err;
    } dec_t;

    dec_t              cur_q, nxt_d;
    logic              is_k, is_jk, dbit, leave;
    logic [DATA_W-1:0] asm_v;

    always_comb begin
        nxt_d       = cur_q;
        nxt_d.valid = 1'b0;
        nxt_d.sop   = 1'b0;
        nxt_d.eop   = 1'b0;
        nxt_d.err   = 1'b0;
        leave       = 1'b0;
        is_k        = (smp_i == LS_K);
        is_jk       = is_k || (smp_i == LS_J);
        dbit        = (is_k == cur_q.lvl);
        asm_v       = {dbit, cur_q.sr[DATA_W-1:1]};

        if (stb_i) begin
            nxt_d.hist = {cur_q.hist[SYNC_LEN-2:0], is_k};
            nxt_d.jk   = {cur_q.jk[SYNC_LEN-2:0], is_jk};

            if (cur_q.st == DS_HUNT) begin
                if ((&nxt_d.jk) && (nxt_d.hist == SYNC_PAT)) begin
                    nxt_d.st   = DS_PKT;
                    nxt_d.sop  = 1'b1;
                    nxt_d.lvl  = 1'b1;          // sync ends on K
                    nxt_d.ones = ONES_W'(1);    // closing sync 1 joins the run
                    nxt_d.nb   = '0;
                    nxt_d.se0  = '0;
                    nxt_d.sr   = '0;
                end
            end else begin
                if (smp_i == LS_SE1) begin
                    nxt_d.err = 1'b1;
                    leave     = 1'b1;
                end else if (smp_i == LS_SE0) begin
                    if (cur_q.se0 != SE0_W'(EOP_MIN))
                        nxt_d.se0 = cur_q.se0 + 1'b1;
                end else if (cur_q.se0 != '0) begin
                    if ((cur_q.se0 == SE0_W'(EOP_MIN)) && !is_k) begin
                        nxt_d.eop = 1'b1;
                        nxt_d.err = (cur_q.nb != '0);
                    end else begin
                        nxt_d.err = 1'b1;
                    end
                    leave = 1'b1;
                end else begin
                    nxt_d.lvl = is_k;
                    if (cur_q.ones == ONES_W'(STUFF_RUN)) begin
                        if (dbit) begin
                            nxt_d.err = 1'b1;
                            leave     = 1'b1;
                        end else begin
                            nxt_d.ones = '0;   // stuffed zero dropped
                        end
                    end else begin
                        nxt_d.ones = dbit ? (cur_q.ones + 1'b1) : '0;
                        nxt_d.sr   = asm_v;
                        if (cur_q.nb == NB_W'(DATA_W - 1)) begin
                            nxt_d.data  = asm_v;
                            nxt_d.valid = 1'b1;
                            nxt_d.nb    = '0;
                        end else begin
                            nxt_d.nb = cur_q.nb + 1'b1;
                        end
                    end
                end

                if (leave) begin
                    nxt_d.st = DS_HUNT;
                    nxt_d.jk = '0;
                end
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cur_q.st    <= DS_HUNT;
            cur_q.hist  <= '0;
            cur_q.jk    <= '0;
            cur_q.lvl   <= 1'b0;
            cur_q.ones  <= '0;
            cur_q.sr    <= '0;
            cur_q.nb    <= '0;
            cur_q.se0   <= '0;
            cur_q.data  <= '0;
            cur_q.valid <= 1'b0;
            cur_q.sop   <= 1'b0;
            cur_q.eop   <= 1'b0;
            cur_q.err   <= 1'b0;
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign data_o  = cur_q.data;
    assign valid_o = cur_q.valid;
    assign sop_o   = cur_q.sop;
    assign eop_o   = cur_q.eop;
    assign err_o   = cur_q.err;

endmodule

// File: rtl/usb_fs_rx.sv
module usb_fs_rx
    import usbfs_rx_pkg::*;
#(
    parameter int OVS         = 4,
    parameter int CENTER      = 2,
    parameter int SYNC_STAGES = 2,
    parameter int DATA_W      = 8,
    parameter int STUFF_RUN   = 6,
    parameter int EOP_MIN     = 2
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              dp_i,
    input  logic              dm_i,
    output logic [DATA_W-1:0] rx_data_o,
    output logic              rx_valid_o,
    output logic              rx_sop_o,
    output logic              rx_eop_o,
    output logic              rx_err_o
);

    line_t ls_sync;
    line_t bit_ls;
    logic  bit_stb;

    usbfs_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .dp_i   (dp_i),
        .dm_i   (dm_i),
        .ls_o   (ls_sync)
    );

    usbfs_rx_dpll #(.OVS(OVS), .CENTER(CENTER)) u_dpll (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .ls_i   (ls_sync),
        .stb_o  (bit_stb),
        .smp_o  (bit_ls)
    );

    usbfs_rx_dec #(
        .DATA_W    (DATA_W),
        .STUFF_RUN (STUFF_RUN),
        .EOP_MIN   (EOP_MIN)
    ) u_dec (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .stb_i   (bit_stb),
        .smp_i   (bit_ls),
        .data_o  (rx_data_o),
        .valid_o (rx_valid_o),
        .sop_o   (rx_sop_o),
        .eop_o   (rx_eop_o),
        .err_o   (rx_err_o)
    );

endmodule

// File: rtl/usbfs_rx_chk.sv
module usbfs_rx_chk (
    input logic clk_i,
    input logic rst_ni,
    input logic bit_stb_i,
    input logic rx_valid_i,
    input logic rx_sop_i,
    input logic rx_eop_i,
    input logic rx_err_i
);

    // R9
    one_sample_per_cell_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        bit_stb_i |=> !bit_stb_i);

    // R3
    byte_strobe_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rx_valid_i |=> !rx_valid_i);

    // R2
    sop_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rx_sop_i |=> !rx_sop_i);

    // R6
    event_exclusive_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $onehot0({rx_valid_i, rx_sop_i, rx_eop_i}));

    // R5
    no_byte_after_err_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rx_err_i |=> !rx_valid_i);

    // R8
    err_not_with_sop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rx_err_i |-> !rx_sop_i);

endmodule

bind usb_fs_rx usbfs_rx_chk chk_i (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .bit_stb_i  (bit_stb),
    .rx_valid_i (rx_valid_o),
    .rx_sop_i   (rx_sop_o),
    .rx_eop_i   (rx_eop_o),
    .rx_err_i   (rx_err_o)
);

// File: tb/usb_fs_rx_tb.sv
module usb_fs_rx_tb_top;

    localparam int CLK_PERIOD = 20;
    localparam int WATCHDOG   = 200000;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       dp, dm;
    logic [7:0] rx_data;
    logic       rx_valid, rx_sop, rx_eop, rx_err;

    int checks   = 0;
    int failures = 0;

    logic [7:0] got [0:63];
    int nget  = 0;
    int n_sop = 0;
    int n_eop = 0;
    int n_err = 0;

    bit cur_k;
    int ones;

    always #(CLK_PERIOD / 2) clk = ~clk;

    usb_fs_rx dut_i (
        .clk_i      (clk),
        .rst_ni     (rst_n),
        .dp_i       (dp),
        .dm_i       (dm),
        .rx_data_o  (rx_data),
        .rx_valid_o (rx_valid),
        .rx_sop_o   (rx_sop),
        .rx_eop_o   (rx_eop),
        .rx_err_o   (rx_err)
    );

    always @(negedge clk) begin
        if (rst_n) begin
            if (rx_valid && nget < 64) begin
                got[nget] = rx_data;
                nget++;
            end
            if (rx_sop) n_sop++;
            if (rx_eop) n_eop++;
            if (rx_err) n_err++;
        end
    end

    task automatic chk_eq(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic drive(input logic [1:0] st, input int n);
        {dp, dm} = st;
        repeat (n) @(negedge clk);
    endtask

    task automatic tx_bit(input bit b, input int n);
        if (!b) cur_k = !cur_k;
        drive(cur_k ? 2'b01 : 2'b10, n);
    endtask

    task automatic tx_sync();
        cur_k = 1'b0;
        for (int i = 0; i < 7; i++) tx_bit(1'b0, 4);
        tx_bit(1'b1, 4);
        ones = 1;
    endtask

    task automatic tx_data(input bit b, input int n);
        tx_bit(b, n);
        if (b) ones++;
        else   ones = 0;
        if (ones == 6) begin
            tx_bit(1'b0, 4);
            ones = 0;
        end
    endtask

    function automatic int cell_len(input bit jit, input int i);
        if (!jit)       return 4;
        if (i % 4 == 1) return 5;
        if (i % 4 == 3) return 3;
        return 4;
    endfunction

    task automatic tx_byte(input logic [7:0] v, input bit jit);
        for (int i = 0; i < 8; i++) tx_data(v[i], cell_len(jit, i));
    endtask

    task automatic tx_eop(input int nse0);
        drive(2'b00, 4 * nse0);
        cur_k = 1'b0;
        drive(2'b10, 32);
    endtask

    task automatic idle(input int n);
        cur_k = 1'b0;
        drive(2'b10, n);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        dp = 1'b1; dm = 1'b0;
        repeat (3) @(negedge clk);
        chk_eq("R1", "valid in reset", int'(rx_valid), 0);
        chk_eq("R1", "data in reset", int'(rx_data), 0);
        rst_n = 1'b1;
        idle(40);
        chk_eq("R1", "idle sop/eop", n_sop + n_eop, 0);
        chk_eq("R1", "idle err", n_err, 0);
        chk_eq("R1", "idle bytes", nget, 0);
    endtask

    task automatic t_basic();
        int b0 = nget, s0 = n_sop, e0 = n_eop, r0 = n_err;
        tx_sync();
        tx_byte(8'hA5, 1'b0);
        tx_byte(8'h3C, 1'b0);
        tx_byte(8'h00, 1'b0);
        tx_eop(2);
        chk_eq("R2", "sop count", n_sop - s0, 1);
        chk_eq("R3", "byte count", nget - b0, 3);
        chk_eq("R3", "byte0", int'(got[b0]), 'hA5);
        chk_eq("R3", "byte1", int'(got[b0 + 1]), 'h3C);
        chk_eq("R3", "byte2", int'(got[b0 + 2]), 'h00);
        chk_eq("R6", "eop count", n_eop - e0, 1);
        chk_eq("R6", "err count", n_err - r0, 0);
        idle(20);
    endtask

    task automatic t_stuff();
        int b0 = nget, e0 = n_eop, r0 = n_err;
        tx_sync();
        tx_byte(8'hFF, 1'b0);
        tx_byte(8'h7E, 1'b0);
        tx_eop(2);
        chk_eq("R4", "byte count", nget - b0, 2);
        chk_eq("R4", "byte 0xFF", int'(got[b0]), 'hFF);
        chk_eq("R4", "byte 0x7E", int'(got[b0 + 1]), 'h7E);
        chk_eq("R4", "err count", n_err - r0, 0);
        chk_eq("R4", "eop count", n_eop - e0, 1);
        idle(20);
    endtask

    task automatic t_run7();
        int b0 = nget, e0 = n_eop, r0 = n_err;
        tx_sync();
        for (int i = 0; i < 7; i++) tx_bit(1'b1, 4);
        tx_eop(2);
        chk_eq("R5", "err count", n_err - r0, 1);
        chk_eq("R5", "eop after abort", n_eop - e0, 0);
        chk_eq("R5", "byte count", nget - b0, 0);
        idle(20);
    endtask

    task automatic t_partial();
        int b0 = nget, e0 = n_eop, r0 = n_err;
        tx_sync();
        tx_byte(8'h5A, 1'b0);
        tx_data(1'b1, 4);
        tx_data(1'b0, 4);
        tx_data(1'b1, 4);
        tx_eop(2);
        chk_eq("R7", "byte count", nget - b0, 1);
        chk_eq("R7", "byte value", int'(got[b0]), 'h5A);
        chk_eq("R7", "eop count", n_eop - e0, 1);
        chk_eq("R7", "err count", n_err - r0, 1);
        idle(20);
    endtask

    task automatic t_short_se0();
        int b0 = nget, e0 = n_eop, r0 = n_err;
        tx_sync();
        tx_byte(8'h81, 1'b0);
        tx_eop(1);
        chk_eq("R8", "byte count", nget - b0, 1);
        chk_eq("R8", "err count", n_err - r0, 1);
        chk_eq("R8", "eop count", n_eop - e0, 0);
        idle(20);
    endtask

    task automatic t_badsync();
        int b0 = nget, s0 = n_sop, e0 = n_eop;
        cur_k = 1'b0;
        for (int i = 0; i < 8; i++) tx_bit(1'b0, 4);
        for (int i = 0; i < 12; i++) tx_bit(1'b1, 4);
        tx_eop(2);
        chk_eq("R2", "near-miss sop", n_sop - s0, 0);
        chk_eq("R2", "near-miss bytes", nget - b0, 0);
        chk_eq("R2", "near-miss eop", n_eop - e0, 0);
        idle(20);
    endtask

    task automatic t_jitter();
        int b0 = nget, e0 = n_eop, r0 = n_err;
        tx_sync();
        tx_byte(8'hC3, 1'b1);
        tx_byte(8'h96, 1'b1);
        tx_byte(8'hF0, 1'b1);
        tx_eop(2);
        chk_eq("R9", "byte count", nget - b0, 3);
        chk_eq("R9", "byte0", int'(got[b0]), 'hC3);
        chk_eq("R9", "byte1", int'(got[b0 + 1]), 'h96);
        chk_eq("R9", "byte2", int'(got[b0 + 2]), 'hF0);
        chk_eq("R9", "eop/err", (n_eop - e0) * 10 + (n_err - r0), 10);
        idle(20);
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        failures++;
        $display("FAIL watchdog: actual=%0d expected=%0d", WATCHDOG, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_basic();
        t_stuff();
        t_run7();
        t_partial();
        t_short_se0();
        t_badsync();
        t_jitter();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule